// File: doc/BRIEF.md
# Synchronous Burst Static Memory

This block is a single-clock static memory holding 18-bit words, each split into two 9-bit byte lanes (eight data bits and one parity bit per lane; parity is stored, never checked). An access begins when one of two active-low start strobes loads an external base address: a processor-side strobe that always reads, and a controller-side strobe that reads or writes depending on the byte write enables. Once a burst has begun, an active-low advance input steps the two lowest address bits through four consecutive words. Holding the advance input high stalls the burst on its current word.

All address, control and write data are captured on the rising edge of the clock, and writes commit on that edge. Read data comes out of a registered pipeline one cycle later. The output is gated by an asynchronous output enable and carries a valid flag in place of a three-state driver. The read path is a one-way stream with no back-pressure: a consumer that cannot take a word must stall the burst through the advance input or the output enable before the word is produced.

Top module: `bsram_burst`

## Requirements
- R1: A synchronous active-high reset deselects the device and clears any pending read, so `rdata_oe` is 0 on the cycle after a reset edge. Memory contents survive reset.
- R2: A clock edge with `cpu_start_n` low and `ce_n` low loads `addr_i` as the new base and performs a read at it. `ctl_start_n`, `we_n` and `wdata` have no effect on that edge.
- R3: A clock edge with `ctl_start_n` low, `cpu_start_n` high and `ce_n` low loads `addr_i`. It writes if any bit of `we_n` is 0 and reads otherwise.
- R4: `ce_n` is looked at only on edges where a start strobe is low. If it is high there, the device is deselected: that edge and all later continue edges neither read nor write, and `rdata_oe` is 0 on the following cycle. On continue edges `ce_n` is ignored.
- R5: On a continue edge (both strobes high, device selected), a low `adv_n` adds 1 modulo 4 to address bits [1:0] before the access. A high `adv_n` repeats the access at the current address (wait state).
- R6: Address bits above bit 1 never change during a burst, so four advances return to the starting word.
- R7: `we_n[0]` low writes `wdata[8:0]` and `we_n[1]` low writes `wdata[17:9]`. The other lane keeps its old contents.
- R8: Data for a read accessed on edge N appears after edge N+1. A read issued on the edge after a write to the same word returns the new data.
- R9: `rdata_oe` is 1 only when `oe_n` is low, the previous edge performed a read, and the current edge performed neither a write nor a deselect. While `rdata_oe` is 0, `rdata` is all zeros.
- R10: A processor-started write takes two edges: a start with `cpu_start_n` low (enables ignored), then a continue edge with a byte enable low that writes `wdata` at the current burst address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| addr_i | input | AW | External base address |
| cpu_start_n | input | 1 | Processor-side burst start, active low, forces read |
| ctl_start_n | input | 1 | Controller-side burst start, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce_n | input | 1 | Chip enable, active low, sampled at burst start |
| we_n | input | 2 | Byte-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| wdata | input | 18 | Write data, two 9-bit lanes |
| rdata | output | 18 | Read data, zero when not driven |
| rdata_oe | output | 1 | Read data valid / driven |

## Verification
The memory is first filled by controller-started write bursts that advance on every edge, so every word holds a known address-derived pattern. Directed sequences then separate the two start sources. A processor start with write enables low must leave memory untouched, while a controller start with the same enables must write. A read burst starting mid-group checks the wrap order against a burst that only stalls, a single-lane write shows which lane each enable reaches, and a deselecting start followed by write attempts shows that chip enable is taken only at load. A seeded random mix of strobes, stalls, lane masks and output enable is then compared against a bench model on every cycle.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_RD   = 2'd1,
    ACC_WR   = 2'd2
  } acc_e;

  localparam int BURST_BITS = 2;
endpackage

// File: rtl/bsram_seq.sv
module bsram_seq
  import bsram_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr_i,
  input  logic          cpu_start_n,
  input  logic          ctl_start_n,
  input  logic          adv_n,
  input  logic          ce_n,
  input  logic          wr_any,
  output acc_e          acc_kind,
  output logic [AW-1:0] acc_addr,
  output logic          desel,
  output logic [AW-1:0] cur_addr,
  output logic          sel
);
  localparam int BB = BURST_BITS;

  logic          sel_q;
  logic [AW-1:0] cur_q;
  logic          load;
  logic [BB-1:0] nxt_lo;

  always_comb begin
    load     = !cpu_start_n || !ctl_start_n;
    nxt_lo   = cur_q[BB-1:0] + {{(BB-1){1'b0}}, ~adv_n};
    desel    = load && ce_n;
    acc_kind = ACC_NONE;
    acc_addr = {cur_q[AW-1:BB], nxt_lo};
    if (load) begin
      acc_addr = addr_i;
      if (!ce_n) begin
        if (!cpu_start_n) acc_kind = ACC_RD;
        else              acc_kind = wr_any ? ACC_WR : ACC_RD;
      end
    end else if (sel_q) begin
      acc_kind = wr_any ? ACC_WR : ACC_RD;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= 1'b0;
      cur_q <= '0;
    end else if (load) begin
      sel_q <= !ce_n;
      cur_q <= addr_i;
    end else if (sel_q) begin
      cur_q <= acc_addr;
    end
  end

  assign cur_addr = cur_q;
  assign sel      = sel_q;
endmodule

// File: rtl/bsram_lane.sv
module bsram_lane #(
  parameter int AW = 8,
  parameter int LW = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [LW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [LW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [LW-1:0] mem [DEPTH];
  logic [LW-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rd_q <= mem[raddr];
  end

  assign rdata = rd_q;
endmodule

// File: rtl/bsram_out.sv
module bsram_out
  import bsram_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  acc_e          acc_kind,
  input  logic [AW-1:0] acc_addr,
  input  logic          desel,
  input  logic          oe_n,
  output logic [AW-1:0] rd_addr,
  output logic          drive
);
  logic          pend_q;
  logic          vld_q;
  logic [AW-1:0] raddr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      pend_q <= (acc_kind == ACC_RD);
      vld_q  <= pend_q && (acc_kind != ACC_WR) && !desel;
    end
  end

  always_ff @(posedge clk) begin
    if (acc_kind == ACC_RD) raddr_q <= acc_addr;
  end

  assign rd_addr = raddr_q;
  assign drive   = vld_q && !oe_n;
endmodule

// File: rtl/bsram_burst.sv
module bsram_burst
  import bsram_pkg::*;
#(
  parameter int AW = 8,
  parameter int LW = 9,
  parameter int NL = 2,
  localparam int DW = LW * NL
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr_i,
  input  logic          cpu_start_n,
  input  logic          ctl_start_n,
  input  logic          adv_n,
  input  logic          ce_n,
  input  logic [NL-1:0] we_n,
  input  logic          oe_n,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rdata_oe
);
  acc_e          acc_kind;
  logic [AW-1:0] acc_addr;
  logic          desel;
  logic [AW-1:0] cur_addr;
  logic          sel;
  logic [AW-1:0] rd_addr;
  logic          drive;
  logic          wr_any;
  logic [NL-1:0] lane_we;
  logic [DW-1:0] lane_q;

  assign wr_any = ~&we_n;

  bsram_seq #(.AW(AW)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .addr_i      (addr_i),
    .cpu_start_n (cpu_start_n),
    .ctl_start_n (ctl_start_n),
    .adv_n       (adv_n),
    .ce_n        (ce_n),
    .wr_any      (wr_any),
    .acc_kind    (acc_kind),
    .acc_addr    (acc_addr),
    .desel       (desel),
    .cur_addr    (cur_addr),
    .sel         (sel)
  );

  always_comb begin
    for (int i = 0; i < NL; i++) begin
      lane_we[i] = (acc_kind == ACC_WR) && !we_n[i];
    end
  end

  for (genvar g = 0; g < NL; g++) begin : g_lane
    bsram_lane #(.AW(AW), .LW(LW)) u_lane (
      .clk   (clk),
      .we    (lane_we[g]),
      .waddr (acc_addr),
      .wdata (wdata[g*LW +: LW]),
      .raddr (rd_addr),
      .rdata (lane_q[g*LW +: LW])
    );
  end

  bsram_out #(.AW(AW)) u_out (
    .clk      (clk),
    .rst      (rst),
    .acc_kind (acc_kind),
    .acc_addr (acc_addr),
    .desel    (desel),
    .oe_n     (oe_n),
    .rd_addr  (rd_addr),
    .drive    (drive)
  );

  assign rdata_oe = drive;
  assign rdata    = drive ? lane_q : '0;
endmodule

// File: rtl/bsram_burst_chk.sv
module bsram_burst_chk #(
  parameter int AW = 8,
  parameter int NL = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          cpu_start_n,
  input logic          ctl_start_n,
  input logic          adv_n,
  input logic          ce_n,
  input logic [NL-1:0] we_n,
  input logic          oe_n,
  input logic          rdata_oe,
  input logic [AW-1:0] cur_addr,
  input logic          sel
);
  logic cont;
  assign cont = cpu_start_n && ctl_start_n;

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !rdata_oe);

  assert_cpu_read_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst, 2) && !$past(rst) && !oe_n &&
     $past(!cpu_start_n && !ce_n, 2) && $past(cont && (&we_n)))
    |-> rdata_oe);

  assert_desel_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    ((!cpu_start_n || !ctl_start_n) && ce_n) |=> !rdata_oe);

  assert_stay_idle_R4: assert property (@(posedge clk) disable iff (rst)
    (!sel && cont) |=> !sel);

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (sel && cont && adv_n) |=> $stable(cur_addr));

  assert_step_R5: assert property (@(posedge clk) disable iff (rst)
    (sel && cont && !adv_n) |=> (cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1));

  assert_upper_fixed_R6: assert property (@(posedge clk) disable iff (rst)
    (sel && cont) |=> (cur_addr[AW-1:2] == $past(cur_addr[AW-1:2])));

  assert_write_hiz_R9: assert property (@(posedge clk) disable iff (rst)
    (sel && cont && !(&we_n)) |=> !rdata_oe);

  assert_oe_gate_R9: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> !rdata_oe);
endmodule

bind bsram_burst bsram_burst_chk #(.AW(AW), .NL(NL)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cpu_start_n (cpu_start_n),
  .ctl_start_n (ctl_start_n),
  .adv_n       (adv_n),
  .ce_n        (ce_n),
  .we_n        (we_n),
  .oe_n        (oe_n),
  .rdata_oe    (rdata_oe),
  .cur_addr    (cur_addr),
  .sel         (sel)
);

// File: tb/bsram_burst_test.sv
`timescale 1ns/1ps
module bsram_burst_test;
  localparam int AW = 8;
  localparam int DW = 18;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic          cpu_start_n = 1'b1;
  logic          ctl_start_n = 1'b1;
  logic          adv_n = 1'b1;
  logic          ce_n = 1'b1;
  logic [1:0]    we_n = 2'b11;
  logic          oe_n = 1'b1;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          rdata_oe;

  always #10 clk = ~clk;

  bsram_burst uut (
    .clk(clk), .rst(rst), .addr_i(addr_i), .cpu_start_n(cpu_start_n),
    .ctl_start_n(ctl_start_n), .adv_n(adv_n), .ce_n(ce_n), .we_n(we_n),
    .oe_n(oe_n), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [DW-1:0] mdl_mem [256];
  logic          m_sel, m_pend, exp_vld;
  logic [AW-1:0] m_cur, m_paddr;
  logic [DW-1:0] exp_data;

  function automatic logic [DW-1:0] pat(input logic [7:0] a);
    return {a[0], a ^ 8'h3C, ~a[0], a};
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge(input logic cpu, input logic ctl, input logic adv, input logic ce,
                            input logic [1:0] we, input logic [7:0] a, input logic [DW-1:0] d);
    int kind = 0;
    bit dsl = 0;
    if (!cpu || !ctl) begin
      if (ce) begin
        dsl = 1; m_sel = 0;
      end else begin
        m_sel = 1; m_cur = a;
        kind = !cpu ? 1 : ((we != 2'b11) ? 2 : 1);
      end
    end else if (m_sel) begin
      if (!adv) m_cur[1:0] = m_cur[1:0] + 2'd1;
      kind = (we != 2'b11) ? 2 : 1;
    end
    exp_vld  = m_pend && (kind != 2) && !dsl;
    exp_data = mdl_mem[m_paddr];
    if (kind == 2) begin
      if (!we[0]) mdl_mem[m_cur][8:0]  = d[8:0];
      if (!we[1]) mdl_mem[m_cur][17:9] = d[17:9];
    end
    m_pend = (kind == 1);
    if (kind == 1) m_paddr = m_cur;
  endtask

  // one clock: drive at negedge, model at posedge, check at next negedge
  task automatic step(input logic cpu, input logic ctl, input logic adv, input logic ce,
                      input logic [1:0] we, input logic oe, input logic [7:0] a,
                      input logic [DW-1:0] d, input string tag);
    cpu_start_n = cpu; ctl_start_n = ctl; adv_n = adv; ce_n = ce;
    we_n = we; oe_n = oe; addr_i = a; wdata = d;
    @(posedge clk);
    model_edge(cpu, ctl, adv, ce, we, a, d);
    @(negedge clk);
    chk({tag, " R9 drive"}, {17'd0, rdata_oe}, {17'd0, exp_vld && !oe});
    chk({tag, " R8 data"}, rdata, (exp_vld && !oe) ? exp_data : '0);
  endtask

  task automatic do_reset();
    rst = 1'b1; cpu_start_n = 1; ctl_start_n = 1; we_n = 2'b11; oe_n = 0;
    @(posedge clk); @(posedge clk);
    m_sel = 0; m_pend = 0; exp_vld = 0;
    @(negedge clk);
    chk("R1 reset drive", {17'd0, rdata_oe}, '0);
    rst = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20251));
    m_cur = '0; m_paddr = '0;
    @(negedge clk);
    do_reset();

    // fill: controller-started write bursts, advancing (R3, R5)
    for (int b = 0; b < 256; b += 4) begin
      step(1, 0, 1, 0, 2'b00, 0, 8'(b), pat(8'(b)), "R3 fill");
      for (int k = 1; k < 4; k++) step(1, 1, 0, 1, 2'b00, 0, 8'h00, pat(8'(b + k)), "R5 fill");
    end

    // wrap from mid-group start 0x46 (R5, R6)
    step(1, 0, 1, 0, 2'b11, 0, 8'h46, '0, "R6 load");
    step(1, 1, 0, 0, 2'b11, 0, 8'h00, '0, "R6 a1");
    step(1, 1, 0, 0, 2'b11, 0, 8'h00, '0, "R6 a2");
    chk("R5 advanced word", rdata, pat(8'h47));
    step(1, 1, 0, 0, 2'b11, 0, 8'h00, '0, "R6 a3");
    step(1, 1, 0, 0, 2'b11, 0, 8'h00, '0, "R6 a4");
    step(1, 1, 1, 0, 2'b11, 0, 8'h00, '0, "R5 wait");
    chk("R6 wrapped to start", rdata, pat(8'h46));
    step(1, 1, 1, 0, 2'b11, 0, 8'h00, '0, "R5 wait2");
    chk("R5 wait state repeats", rdata, pat(8'h46));

    // processor start ignores enables and controller strobe (R2)
    step(0, 0, 1, 0, 2'b00, 0, 8'h20, 18'h3FFFF, "R2 start");
    step(1, 1, 1, 0, 2'b11, 0, 8'h00, '0, "R2 cont");
    chk("R2 no write on start", rdata, pat(8'h20));
    step(1, 1, 1, 0, 2'b11, 0, 8'h00, '0, "R2 cont2");
    chk("R2 still old data", rdata, pat(8'h20));

    // processor-started two-edge write (R10)
    step(0, 1, 1, 0, 2'b11, 0, 8'h10, '0, "R10 start");
    step(1, 1, 1, 0, 2'b00, 0, 8'h00, 18'h2AAAA, "R10 write");
    step(1, 0, 1, 0, 2'b11, 0, 8'h10, '0, "R10 read");
    step(1, 1, 1, 0, 2'b11, 0, 8'h00, '0, "R10 hold");
    chk("R10 written word", rdata, 18'h2AAAA);

    // single lane write (R7)
    step(1, 0, 1, 0, 2'b10, 0, 8'h30, 18'h3FFFF, "R7 lane0");
    step(1, 0, 1, 0, 2'b11, 0, 8'h30, '0, "R7 read");
    step(1, 1, 1, 0, 2'b11, 0, 8'h00, '0, "R7 hold");
    chk("R7 lane0 only", rdata, {pat(8'h30)[17:9], 9'h1FF});

    // read right after write (R8)
    step(1, 0, 1, 0, 2'b00, 0, 8'h31, 18'h15A5A, "R8 write");
    step(1, 0, 1, 0, 2'b11, 0, 8'h31, '0, "R8 read");
    step(1, 1, 1, 0, 2'b11, 0, 8'h00, '0, "R8 hold");
    chk("R8 new data", rdata, 18'h15A5A);

    // deselect at load, write attempts ignored (R4)
    step(1, 0, 1, 1, 2'b00, 0, 8'h50, '0, "R4 desel");
    chk("R4 no drive after desel", {17'd0, rdata_oe}, '0);
    step(1, 1, 0, 0, 2'b00, 0, 8'h00, '0, "R4 cont");
    step(1, 1, 1, 0, 2'b00, 0, 8'h00, '0, "R4 cont2");
    step(1, 0, 1, 0, 2'b11, 0, 8'h50, '0, "R4 read");
    step(1, 1, 1, 1, 2'b11, 0, 8'h00, '0, "R4 ce ignored");
    chk("R4 driven with ce high", {17'd0, rdata_oe}, 18'd1);
    chk("R4 word untouched", rdata, pat(8'h50));

    // output enable high gates data (R9)
    step(1, 1, 1, 0, 2'b11, 1, 8'h00, '0, "R9 oe high");
    chk("R9 zero when gated", rdata, '0);

    // reset keeps memory (R1)
    do_reset();
    step(1, 0, 1, 0, 2'b11, 0, 8'h46, '0, "R1 read");
    step(1, 1, 1, 0, 2'b11, 0, 8'h00, '0, "R1 hold");
    chk("R1 memory kept", rdata, pat(8'h46));

    // seeded random mix
    for (int i = 0; i < 4000; i++) begin
      logic c, t, v, e, o;
      logic [1:0] w;
      c = ($urandom_range(99) < 12) ? 1'b0 : 1'b1;
      t = ($urandom_range(99) < 15) ? 1'b0 : 1'b1;
      v = ($urandom_range(99) < 60) ? 1'b0 : 1'b1;
      e = ($urandom_range(99) < 88) ? 1'b0 : 1'b1;
      o = ($urandom_range(99) < 85) ? 1'b0 : 1'b1;
      w = ($urandom_range(99) < 55) ? 2'b11 : 2'($urandom_range(2));
      step(c, t, v, e, w, o, 8'($urandom_range(255)), 18'($urandom), "rand");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #4_000_000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule